// File: doc/BRIEF.md
# Fuse Write Permission Filter

This block stands between the software-facing write path and the one-time-programmable fuse array. It decides whether each requested fuse word write is allowed, and it sends only allowed writes on to the fuse port. It keeps a copy of the lifecycle code and of the 32-bit lock word. Both copies are loaded from the fuse image after power-up and are updated when a write to either word is granted.

Every request carries a byte offset and a 32-bit data word. The offset is decoded into one of these targets: a fixed asset field, the lifecycle word, the lock word, a 128-bit block of the user non-secure region, a 128-bit block of the user secure region, or the test area. The sizes of the user regions are parameters. Permission depends on the lifecycle code, on the lock bit that covers the target, and, for the lifecycle word, on the value being written. One cycle after the request, the block answers with either a grant or a deny with a reason code.

Top module: `otp_write_filter`

## Requirements
- R1: During and after reset, and until an image load, all outputs are zero. The held state is lifecycle 111 with every lock bit set, so a write to offset 0x000 is denied with reason 2, a write to 0x080 with reason 4, and a write to the first secure block with reason 3.
- R2: A request sampled on a clock edge is answered on the next edge by exactly one of `grant` or `deny`. A cycle without a request gives neither. Reason codes are: 0 granted, 1 unmapped, 2 fixed area closed, 3 secure region revoked, 4 locked, 5 reserved lifecycle bit, 6 lifecycle not advancing.
- R3: On a grant, `fuse_addr` and `fuse_data` carry the request offset and data. On a deny, and in idle cycles, both are zero.
- R4: A misaligned offset (bits 1:0 not zero), an offset from 0x06C to 0x07B, or an offset at or past the end of the test area is denied with reason 1.
- R5: Lock bit 0 covers 0x000–0x003, bit 1 covers 0x004–0x013, bit 2 covers 0x014–0x017, bit 3 covers 0x018–0x027, bit 4 covers 0x028–0x047 and bit 5 covers 0x048–0x067. A write to a covered field whose lock bit is set is denied with reason 4.
- R6: The non-secure region starts at 0x080. Its block n (16 bytes each) is locked by bit 8+n for n below 8. Blocks from 8 on are never locked.
- R7: The secure region starts right after the non-secure region. Its block n is locked by bit 16+n for n below 16. Blocks from 16 on are never locked.
- R8: In lifecycle 011 (deployment) or 111 (revocation), a write to 0x000–0x067 is denied with reason 2. This check takes precedence over the lock bits.
- R9: In lifecycle 111, any write to the secure region is denied with reason 3. This check takes precedence over the lock bits.
- R10: A write to the lifecycle word at 0x068 with data bit 3 set is denied with reason 5. Otherwise, if data bits 2:0 are not one of 000, 001, 011, 111, or if they would clear a bit of the held code, the write is denied with reason 6.
- R11: A granted write to 0x068 replaces the held lifecycle code with data bits 2:0. A granted write to the lock word at 0x07C ORs the data into the held lock word, so lock bits never clear.
- R12: An image load replaces both held values on the next edge. If a granted write to the same word happens in the same cycle, the image load wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| img_load | input | 1 | Load held lifecycle code and lock word from the fuse image |
| img_lcs | input | 3 | Lifecycle code from the image |
| img_lock | input | 32 | Lock word from the image |
| req | input | 1 | Write request strobe |
| req_off | input | AW | Byte offset of the target word |
| req_data | input | 32 | Data to be written |
| grant | output | 1 | Write allowed; strobe for the fuse port |
| deny | output | 1 | Write refused |
| deny_code | output | 3 | Reason code (0 when granted or idle) |
| fuse_addr | output | AW | Offset forwarded to the fuse array |
| fuse_data | output | 32 | Data forwarded to the fuse array |

## Verification
The bench uses a 160-byte non-secure region and a 288-byte secure region, which gives ten and eighteen blocks. At these sizes, blocks exist past both lock caps, so it can show that the highest blocks stay writable even when all lock bits are set. A test area of 64 bytes puts the end of the map at 0x280. The sweep therefore walks every aligned offset up to one word past the end, in each lifecycle state, once with a clear lock word and once with a random lock word.

// File: rtl/otp_wf_pkg.sv
package otp_wf_pkg;

  // lifecycle codes, each one a superset of the bits of the one before
  localparam logic [2:0] LC_CM = 3'b000;
  localparam logic [2:0] LC_DM = 3'b001;
  localparam logic [2:0] LC_DD = 3'b011;
  localparam logic [2:0] LC_DR = 3'b111;

  // fixed layout below the user regions
  localparam int unsigned LCW_OFF   = 32'h68;
  localparam int unsigned LOCKW_OFF = 32'h7C;
  localparam int unsigned USER_BASE = 32'h80;
  localparam int unsigned BLK_SHIFT = 4;     // 16-byte lock granule
  localparam int unsigned NSEC_CAP  = 8;     // lockable non-secure blocks
  localparam int unsigned SEC_CAP   = 16;    // lockable secure blocks
  localparam int unsigned NSEC_LBIT = 8;
  localparam int unsigned SEC_LBIT  = 16;
  localparam int unsigned NUM_FLD   = 6;

  typedef enum logic [2:0] {
    RSN_OK       = 3'd0,
    RSN_UNMAPPED = 3'd1,
    RSN_AREA     = 3'd2,
    RSN_REVOKED  = 3'd3,
    RSN_LOCKED   = 3'd4,
    RSN_RSVD     = 3'd5,
    RSN_BACKWARD = 3'd6
  } rsn_e;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_FIXED,
    RG_LCW,
    RG_LOCKW,
    RG_NSEC,
    RG_SEC,
    RG_TEST
  } rgn_e;

  typedef struct packed {
    rgn_e       kind;
    logic       lockable;
    logic [4:0] lock_idx;
  } dec_t;

endpackage

// File: rtl/otp_wf_decode.sv
module otp_wf_decode
  import otp_wf_pkg::*;
#(
  parameter int unsigned AW         = 12,
  parameter int unsigned NSEC_BYTES = 160,
  parameter int unsigned SEC_BYTES  = 288,
  parameter int unsigned TEST_BYTES = 64
) (
  input  logic [AW-1:0] off,
  output dec_t          dec
);

  localparam int unsigned SEC_BASE  = USER_BASE + NSEC_BYTES;
  localparam int unsigned TEST_BASE = SEC_BASE + SEC_BYTES;
  localparam int unsigned END_OFF   = TEST_BASE + TEST_BYTES;

  // exclusive upper bound of each fixed field, ordered by lock bit
  localparam int unsigned FLD_END [NUM_FLD] = '{32'h04, 32'h14, 32'h18, 32'h28, 32'h48, 32'h68};

  logic [31:0] o;
  logic [31:0] blk;
  logic        hit;

  always_comb begin
    o            = 32'(off);
    blk          = '0;
    hit          = 1'b0;
    dec.kind     = RG_NONE;
    dec.lockable = 1'b0;
    dec.lock_idx = '0;
    if (o[1:0] == 2'b00) begin
      if (o < LCW_OFF) begin
        dec.kind     = RG_FIXED;
        dec.lockable = 1'b1;
        for (int i = 0; i < NUM_FLD; i++) begin
          if (!hit && o < FLD_END[i]) begin
            hit          = 1'b1;
            dec.lock_idx = 5'(i);
          end
        end
      end else if (o == LCW_OFF) begin
        dec.kind = RG_LCW;
      end else if (o == LOCKW_OFF) begin
        dec.kind = RG_LOCKW;
      end else if (o >= USER_BASE && o < SEC_BASE) begin
        dec.kind     = RG_NSEC;
        blk          = (o - USER_BASE) >> BLK_SHIFT;
        dec.lockable = (blk < NSEC_CAP);
        dec.lock_idx = dec.lockable ? 5'(NSEC_LBIT + blk) : 5'd0;
      end else if (o >= SEC_BASE && o < TEST_BASE) begin
        dec.kind     = RG_SEC;
        blk          = (o - SEC_BASE) >> BLK_SHIFT;
        dec.lockable = (blk < SEC_CAP);
        dec.lock_idx = dec.lockable ? 5'(SEC_LBIT + blk) : 5'd0;
      end else if (o >= TEST_BASE && o < END_OFF) begin
        dec.kind = RG_TEST;
      end
    end
  end

endmodule

// File: rtl/otp_wf_policy.sv
module otp_wf_policy
  import otp_wf_pkg::*;
(
  input  dec_t        dec,
  input  logic [2:0]  lcs,
  input  logic [31:0] lock,
  input  logic [31:0] wdata,
  output rsn_e        rsn
);

  logic       deployed;
  logic       revoked;
  logic       locked;
  logic [2:0] nxt;
  logic       nxt_valid;

  always_comb begin
    deployed  = (lcs == LC_DD) || (lcs == LC_DR);
    revoked   = (lcs == LC_DR);
    locked    = dec.lockable && lock[dec.lock_idx];
    nxt       = wdata[2:0];
    nxt_valid = (nxt == LC_CM) || (nxt == LC_DM) || (nxt == LC_DD) || (nxt == LC_DR);
    rsn       = RSN_OK;
    case (dec.kind)
      RG_NONE:  rsn = RSN_UNMAPPED;
      RG_FIXED: begin
        if (deployed)    rsn = RSN_AREA;
        else if (locked) rsn = RSN_LOCKED;
      end
      RG_SEC: begin
        if (revoked)     rsn = RSN_REVOKED;
        else if (locked) rsn = RSN_LOCKED;
      end
      RG_NSEC: begin
        if (locked) rsn = RSN_LOCKED;
      end
      RG_LCW: begin
        if (wdata[3])                                 rsn = RSN_RSVD;
        else if (!nxt_valid || ((lcs & ~nxt) != 3'b0)) rsn = RSN_BACKWARD;
      end
      default: rsn = RSN_OK;
    endcase
  end

endmodule

// File: rtl/otp_wf_state.sv
module otp_wf_state
  import otp_wf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        img_load,
  input  logic [2:0]  img_lcs,
  input  logic [31:0] img_lock,
  input  logic        upd_lcs,
  input  logic        upd_lock,
  input  logic [31:0] wdata,
  output logic [2:0]  lcs_q,
  output logic [31:0] lock_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lcs_q  <= LC_DR;
      lock_q <= '1;
    end else if (img_load) begin
      lcs_q  <= img_lcs;
      lock_q <= img_lock;
    end else begin
      if (upd_lcs)  lcs_q  <= wdata[2:0];
      if (upd_lock) lock_q <= lock_q | wdata;
    end
  end

  AST_LCS_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(img_load)) |-> ((lcs_q & $past(lcs_q)) == $past(lcs_q))); // R11
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(img_load)) |-> ((lock_q & $past(lock_q)) == $past(lock_q))); // R11
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(img_load)) |-> (lcs_q == $past(img_lcs) && lock_q == $past(img_lock))); // R12

endmodule

// File: rtl/otp_write_filter.sv
module otp_write_filter
  import otp_wf_pkg::*;
#(
  parameter int unsigned AW         = 12,
  parameter int unsigned NSEC_BYTES = 160,
  parameter int unsigned SEC_BYTES  = 288,
  parameter int unsigned TEST_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          img_load,
  input  logic [2:0]    img_lcs,
  input  logic [31:0]   img_lock,
  input  logic          req,
  input  logic [AW-1:0] req_off,
  input  logic [31:0]   req_data,
  output logic          grant,
  output logic          deny,
  output logic [2:0]    deny_code,
  output logic [AW-1:0] fuse_addr,
  output logic [31:0]   fuse_data
);

  localparam int unsigned SEC_LO = USER_BASE + NSEC_BYTES;
  localparam int unsigned SEC_HI = SEC_LO + SEC_BYTES;

  dec_t        dec;
  rsn_e        rsn;
  logic [2:0]  lcs_q;
  logic [31:0] lock_q;
  logic        pass;
  logic        upd_lcs;
  logic        upd_lock;

  otp_wf_decode #(
    .AW(AW), .NSEC_BYTES(NSEC_BYTES), .SEC_BYTES(SEC_BYTES), .TEST_BYTES(TEST_BYTES)
  ) u_dec (
    .off (req_off),
    .dec (dec)
  );

  otp_wf_policy u_pol (
    .dec   (dec),
    .lcs   (lcs_q),
    .lock  (lock_q),
    .wdata (req_data),
    .rsn   (rsn)
  );

  assign pass     = req && (rsn == RSN_OK);
  assign upd_lcs  = pass && (dec.kind == RG_LCW);
  assign upd_lock = pass && (dec.kind == RG_LOCKW);

  otp_wf_state u_st (
    .clk      (clk),
    .rst      (rst),
    .img_load (img_load),
    .img_lcs  (img_lcs),
    .img_lock (img_lock),
    .upd_lcs  (upd_lcs),
    .upd_lock (upd_lock),
    .wdata    (req_data),
    .lcs_q    (lcs_q),
    .lock_q   (lock_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant     <= 1'b0;
      deny      <= 1'b0;
      deny_code <= '0;
      fuse_addr <= '0;
      fuse_data <= '0;
    end else begin
      grant     <= pass;
      deny      <= req && !pass;
      deny_code <= req ? rsn : RSN_OK;
      fuse_addr <= pass ? req_off : '0;
      fuse_data <= pass ? req_data : '0;
    end
  end

  AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((grant || deny) == $past(req) && !(grant && deny))); // R2
  AST_FUSE_MATCH: assert property (@(posedge clk) disable iff (rst)
    grant |-> (fuse_addr == $past(req_off) && fuse_data == $past(req_data))); // R3
  AST_FIXED_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (grant && $past(lcs_q[1])) |-> (32'(fuse_addr) >= LCW_OFF)); // R8
  AST_SEC_REVOKED: assert property (@(posedge clk) disable iff (rst)
    (grant && $past(lcs_q) == LC_DR) |-> (32'(fuse_addr) < SEC_LO || 32'(fuse_addr) >= SEC_HI)); // R9

endmodule

// File: tb/otp_write_filter_tb_top.sv
module otp_write_filter_tb_top;

  localparam int AW = 12;
  localparam int NSEC = 160;
  localparam int SEC = 288;
  localparam int TST = 64;
  localparam int SEC_BASE = 128 + NSEC;
  localparam int TST_BASE = SEC_BASE + SEC;
  localparam int END_OFF = TST_BASE + TST;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          img_load = 1'b0;
  logic [2:0]    img_lcs = '0;
  logic [31:0]   img_lock = '0;
  logic          req = 1'b0;
  logic [AW-1:0] req_off = '0;
  logic [31:0]   req_data = '0;
  logic          grant;
  logic          deny;
  logic [2:0]    deny_code;
  logic [AW-1:0] fuse_addr;
  logic [31:0]   fuse_data;

  int          n_chk = 0;
  int          n_err = 0;
  logic [2:0]  m_lcs = 3'b111;
  logic [31:0] m_lock = '1;

  always #2 clk = ~clk;

  otp_write_filter #(.AW(AW), .NSEC_BYTES(NSEC), .SEC_BYTES(SEC), .TEST_BYTES(TST)) dut_i (
    .clk(clk), .rst(rst), .img_load(img_load), .img_lcs(img_lcs), .img_lock(img_lock),
    .req(req), .req_off(req_off), .req_data(req_data), .grant(grant), .deny(deny),
    .deny_code(deny_code), .fuse_addr(fuse_addr), .fuse_data(fuse_data)
  );

  // table entry: lcs(3) lock(32) offset(12) data(32) expected reason(3)
  localparam int NV = 19;
  localparam logic [81:0] VEC [NV] = '{
    {3'b000, 32'h0000_0000, 12'h000, 32'h0000_0001, 3'd0},
    {3'b000, 32'h0000_0001, 12'h000, 32'h0000_0001, 3'd4},
    {3'b001, 32'h0000_0002, 12'h010, 32'h0000_00FF, 3'd4},
    {3'b011, 32'h0000_0000, 12'h018, 32'h0000_0001, 3'd2},
    {3'b011, 32'h0000_0000, 12'h068, 32'h0000_0007, 3'd0},
    {3'b001, 32'h0000_0000, 12'h068, 32'h0000_0000, 3'd6},
    {3'b000, 32'h0000_0000, 12'h068, 32'h0000_0008, 3'd5},
    {3'b001, 32'h0000_0000, 12'h068, 32'h0000_0002, 3'd6},
    {3'b000, 32'h0000_0000, 12'h070, 32'h0000_0001, 3'd1},
    {3'b000, 32'h0000_0000, 12'h002, 32'h0000_0001, 3'd1},
    {3'b001, 32'h0000_0100, 12'h080, 32'h0000_0001, 3'd4},
    {3'b001, 32'hFFFF_FFFF, 12'h100, 32'h0000_0055, 3'd0},
    {3'b001, 32'hFFFF_FFFF, 12'h220, 32'h0000_0066, 3'd0},
    {3'b001, 32'h0001_0000, 12'h120, 32'h0000_0001, 3'd4},
    {3'b111, 32'h0000_0000, 12'h120, 32'h0000_0001, 3'd3},
    {3'b111, 32'h0000_0000, 12'h240, 32'h0000_0001, 3'd0},
    {3'b000, 32'h0000_0000, 12'h280, 32'h0000_0001, 3'd1},
    {3'b011, 32'hFFFF_FFFF, 12'h07C, 32'h0000_0000, 3'd0},
    {3'b011, 32'hFFFF_FFFF, 12'h0F0, 32'h0000_0001, 3'd4}
  };

  function automatic logic [2:0] ref_rsn(input int o, input logic [31:0] d,
                                         input logic [2:0] lc, input logic [31:0] lk);
    int b;
    int idx;
    if ((o % 4) != 0 || o >= END_OFF || (o >= 'h6C && o < 'h7C)) return 3'd1;
    if (o < 'h68) begin
      if (lc == 3'b011 || lc == 3'b111) return 3'd2;
      idx = (o < 'h04) ? 0 : (o < 'h14) ? 1 : (o < 'h18) ? 2 : (o < 'h28) ? 3 : (o < 'h48) ? 4 : 5;
      return lk[idx] ? 3'd4 : 3'd0;
    end
    if (o == 'h68) begin
      if (d[3]) return 3'd5;
      if (!(d[2:0] == 3'b000 || d[2:0] == 3'b001 || d[2:0] == 3'b011 || d[2:0] == 3'b111)) return 3'd6;
      if ((lc & ~d[2:0]) != 3'b000) return 3'd6;
      return 3'd0;
    end
    if (o == 'h7C) return 3'd0;
    if (o < SEC_BASE) begin
      b = (o - 128) / 16;
      return (b < 8 && lk[8 + b]) ? 3'd4 : 3'd0;
    end
    if (o < TST_BASE) begin
      if (lc == 3'b111) return 3'd3;
      b = (o - SEC_BASE) / 16;
      return (b < 16 && lk[16 + b]) ? 3'd4 : 3'd0;
    end
    return 3'd0;
  endfunction

  task automatic load_img(input logic [2:0] lc, input logic [31:0] lk);
    @(negedge clk);
    img_load = 1'b1; img_lcs = lc; img_lock = lk;
    @(negedge clk);
    img_load = 1'b0;
    m_lcs = lc; m_lock = lk;
  endtask

  task automatic do_req(input logic [AW-1:0] off, input logic [31:0] d,
                        input logic [2:0] exp, input string tag);
    bit ok;
    @(negedge clk);
    req = 1'b1; req_off = off; req_data = d;
    @(negedge clk);
    req = 1'b0;
    ok = (grant == (exp == 3'd0)) && (deny == (exp != 3'd0)) && (deny_code == exp) &&
         (fuse_addr == ((exp == 3'd0) ? off : '0)) && (fuse_data == ((exp == 3'd0) ? d : 32'h0));
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s off=%h: actual g=%0b d=%0b code=%0d addr=%h data=%h, expected code=%0d addr=%h data=%h",
               tag, off, grant, deny, deny_code, fuse_addr, fuse_data, exp,
               (exp == 3'd0) ? off : '0, (exp == 3'd0) ? d : 32'h0);
    end
    if (exp == 3'd0) begin
      if (off == 12'h068) m_lcs = d[2:0];
      if (off == 12'h07C) m_lock = m_lock | d;
    end
  endtask

  task automatic chk_idle(input string tag);
    n_chk++;
    if (grant || deny || deny_code != 3'd0 || fuse_addr != '0 || fuse_data != 32'h0) begin
      n_err++;
      $display("FAIL %s idle: actual g=%0b d=%0b code=%0d addr=%h data=%h, expected all zero",
               tag, grant, deny, deny_code, fuse_addr, fuse_data);
    end
  endtask

  initial begin : watchdog
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic [2:0]  lc_seq [4] = '{3'b000, 3'b001, 3'b011, 3'b111};
    logic [31:0] d;
    repeat (4) @(negedge clk);
    chk_idle("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1 after reset");
    // held state defaults to revoked, fully locked
    do_req(12'h000, 32'h1, 3'd2, "R1 fixed");
    do_req(12'h080, 32'h1, 3'd4, "R1 nsec");
    do_req(12'h120, 32'h1, 3'd3, "R1 sec");

    // vector table
    for (int i = 0; i < NV; i++) begin
      load_img(VEC[i][81:79], VEC[i][78:47]);
      do_req(VEC[i][46:35], VEC[i][34:3], VEC[i][2:0], "table R4 R5 R6 R7 R8 R9 R10");
    end

    // R2: no request, no answer
    @(negedge clk);
    chk_idle("R2");

    // R11: lock word sticky, lifecycle advance closes fixed area
    load_img(3'b001, 32'h0);
    do_req(12'h000, 32'hA5, 3'd0, "R11 pre");
    do_req(12'h07C, 32'h1, 3'd0, "R11 lockw");
    do_req(12'h000, 32'hA5, 3'd4, "R11 locked");
    do_req(12'h07C, 32'h0, 3'd0, "R11 lockw zero");
    do_req(12'h000, 32'hA5, 3'd4, "R11 still locked");
    do_req(12'h068, 32'h3, 3'd0, "R11 advance");
    do_req(12'h018, 32'h1, 3'd2, "R11 deployed");
    do_req(12'h068, 32'h1, 3'd6, "R10 backward");
    do_req(12'h068, 32'h7, 3'd0, "R11 revoke");
    do_req(12'h130, 32'h1, 3'd3, "R9 after advance");

    // R12: load wins over same-cycle lifecycle write
    load_img(3'b001, 32'h0);
    @(negedge clk);
    img_load = 1'b1; img_lcs = 3'b000; img_lock = 32'h0;
    req = 1'b1; req_off = 12'h068; req_data = 32'h3;
    @(negedge clk);
    img_load = 1'b0; req = 1'b0;
    n_chk++;
    if (!(grant && fuse_addr == 12'h068)) begin
      n_err++;
      $display("FAIL R12 same-cycle grant: actual g=%0b addr=%h, expected g=1 addr=068", grant, fuse_addr);
    end
    m_lcs = 3'b000; m_lock = 32'h0;
    do_req(12'h068, 32'h1, 3'd0, "R12 load kept");

    // full offset sweep against the reference model
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 2; k++) begin
        load_img(lc_seq[s], (k == 0) ? 32'h0 : $urandom);
        for (int o = 0; o <= END_OFF; o += 4) begin
          d = $urandom;
          do_req(AW'(o), d, ref_rsn(o, d, m_lcs, m_lock), "sweep R4 R5 R6 R7 R8 R9 R10");
        end
        do_req(AW'(SEC_BASE + 1), 32'h1, 3'd1, "R4 misaligned");
      end
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule